// File: doc/BRIEF.md
# External Interrupt Entry Unit

This unit decides when a simple 32-bit processor core leaves its normal flow to service an external interrupt. Thirty-two request lines feed a sticky pending register. Alongside it sit a mask register, a two-bit enable register (global enable in bit 0, saved enable in bit 1) and an exception base address register. All four are reachable through a small register port with a 2-bit select, a write strobe and combinational read data.

The core raises `insn_done_i` for one cycle whenever an instruction retires and presents that instruction's successor PC on `pc_i`. In such a cycle the unit checks whether the global enable is set and whether any pending bit is also unmasked. If so, it moves from state ST_WAIT to state ST_ENTER (transition "accept") and updates the enable register at the same edge. In ST_ENTER it asserts `take_o` for exactly one cycle. During that cycle it asks for the captured PC to be written into general register 30 and presents the redirect PC, which is the base address plus the interrupt exception ID times 32. It then returns to ST_WAIT (transition "retire"). In ST_WAIT without a qualifying boundary, the unit stays put (transition "hold").

Top module: `irq_entry_unit`

## Requirements
- R1: After reset the enable, mask, pending and base registers all read as zero and `take_o` and `gpr_we_o` are low.
- R2: A high level on `irq_i[n]` in a cycle sets pending bit n, and the bit is visible from the next cycle. A line that drops does not clear its bit.
- R3: A register write to the pending register (select 2) clears every pending bit whose data bit is 1. If the line of a bit is high in the same cycle, that bit stays set.
- R4: An entry is started only in a cycle with `insn_done_i` high, enable bit 0 equal to 1 and a nonzero AND of mask and pending. No entry happens otherwise, and a boundary seen during ST_ENTER is ignored.
- R5: The cycle after an accepted boundary, `take_o` and `gpr_we_o` are high for exactly one cycle, with `gpr_idx_o` = 30 and `gpr_data_o` equal to `pc_i` of the boundary cycle.
- R6: During the entry cycle `redirect_pc_o` equals the base register plus EXC_ID*32 (0xC0 with the default EXC_ID of 6).
- R7: On entry the enable register becomes 2'b10, and `ie_o` shows it in the entry cycle. A register write to the enable register in the accepting cycle is overridden.
- R8: Bits [7:0] of the base register are not stored and always read as zero. Bits [31:8] take the written data.
- R9: A pending interrupt that was blocked by its mask or by the enable is taken at the first boundary after software unmasks it or re-enables.
- R10: The select code picks the register: 0 enable (bits 1:0, upper bits read zero), 1 mask, 2 pending, 3 base. Writes take effect at the clock edge when `csr_we_i` is high, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 32 | External interrupt request lines, level sensitive |
| insn_done_i | input | 1 | Instruction boundary from the core |
| pc_i | input | 32 | Return PC presented with the boundary |
| csr_sel_i | input | 2 | Register select: 0 enable, 1 mask, 2 pending, 3 base |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Combinational read data for the selected register |
| take_o | output | 1 | One-cycle pulse: interrupt entry taken |
| redirect_pc_o | output | 32 | Handler address, valid while `take_o` is high |
| gpr_we_o | output | 1 | Request to write the exception-address register |
| gpr_idx_o | output | 5 | Destination register index (30 during entry) |
| gpr_data_o | output | 32 | Return address to store |
| ie_o | output | 2 | Current enable bits {saved, global} |

## Verification
Directed sequences cover sticky pending versus a dropped line, a clear that collides with a still-high line, a boundary with everything pending but masked, unmasking followed by entry, and an enable write that collides with an accepting boundary. These tell set-wins from clear-wins, level from edge capture, and register from CSR priority. A long run of sparse random pulses on single lines, random register writes and boundaries in about half the cycles then compares every output against a cycle model each cycle. That run finds ordering faults between the mask, the enable and the pending registers that the directed cases miss.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        SEL_IE  = 2'd0,
        SEL_IM  = 2'd1,
        SEL_IP  = 2'd2,
        SEL_EBA = 2'd3
    } csr_sel_e;

    typedef enum logic {
        ST_WAIT  = 1'b0,
        ST_ENTER = 1'b1
    } entry_state_e;

    // {saved enable, global enable} after an entry
    localparam logic [1:0] IE_ON_ENTRY = 2'b10;

endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    output logic [NUM_IRQ-1:0] ip_o
);

    logic [NUM_IRQ-1:0] ip_q;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
        // set wins over a same-cycle clear
        always_ff @(posedge clk) begin
            if (!rst_n) ip_q[g] <= 1'b0;
            else        ip_q[g] <= irq_i[g] | (ip_q[g] & ~clr_i[g]);
        end

        assert_line_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            irq_i[g] |=> ip_q[g]);

        assert_sticky_without_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ip_q[g] && !clr_i[g]) |=> ip_q[g]);
    end

    assign ip_o = ip_q;

endmodule

// File: rtl/irq_csr_bank.sv
module irq_csr_bank
    import irq_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NUM_IRQ    = 32,
    parameter int ALIGN_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         sel_i,
    input  logic               we_i,
    input  logic [XLEN-1:0]    wdata_i,
    input  logic               enter_i,
    input  logic [NUM_IRQ-1:0] ip_i,
    output logic [XLEN-1:0]    rdata_o,
    output logic [1:0]         ie_o,
    output logic [NUM_IRQ-1:0] im_o,
    output logic [XLEN-1:0]    eba_o,
    output logic [NUM_IRQ-1:0] ip_clr_o
);

    csr_sel_e sel;
    assign sel = csr_sel_e'(sel_i);

    logic [1:0]               ie_q;
    logic [NUM_IRQ-1:0]       im_q;
    logic [XLEN-1:ALIGN_BITS] eba_hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                       ie_q <= '0;
        else if (enter_i)                 ie_q <= IE_ON_ENTRY;
        else if (we_i && sel == SEL_IE)   ie_q <= wdata_i[1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       im_q <= '0;
        else if (we_i && sel == SEL_IM)   im_q <= wdata_i[NUM_IRQ-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       eba_hi_q <= '0;
        else if (we_i && sel == SEL_EBA)  eba_hi_q <= wdata_i[XLEN-1:ALIGN_BITS];
    end

    assign ip_clr_o = (we_i && sel == SEL_IP) ? wdata_i[NUM_IRQ-1:0] : '0;
    assign ie_o     = ie_q;
    assign im_o     = im_q;
    assign eba_o    = {eba_hi_q, {ALIGN_BITS{1'b0}}};

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_IE:  rdata_o[1:0]         = ie_q;
            SEL_IM:  rdata_o[NUM_IRQ-1:0] = im_q;
            SEL_IP:  rdata_o[NUM_IRQ-1:0] = ip_i;
            SEL_EBA: rdata_o              = eba_o;
        endcase
    end

    assert_entry_sets_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> ie_q == IE_ON_ENTRY);

    assert_base_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == SEL_EBA) |=> eba_o[XLEN-1:ALIGN_BITS] == $past(wdata_i[XLEN-1:ALIGN_BITS]));

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 32,
    parameter int EXC_ID  = 6,
    parameter int EPC_REG = 30,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_done_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic               gie_i,
    input  logic [NUM_IRQ-1:0] im_i,
    input  logic [NUM_IRQ-1:0] ip_i,
    input  logic [XLEN-1:0]    eba_i,
    output logic               enter_o,
    output logic               take_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic               gpr_we_o,
    output logic [IDX_W-1:0]   gpr_idx_o,
    output logic [XLEN-1:0]    gpr_data_o
);

    localparam logic [XLEN-1:0]  VEC_OFS = XLEN'(EXC_ID * 32);
    localparam logic [IDX_W-1:0] EPC_IDX = IDX_W'(EPC_REG);

    entry_state_e       state_q, state_d;
    logic [XLEN-1:0]    pc_q;
    logic               hit;

    assign hit = |(im_i & ip_i);

    // next state
    always_comb begin
        state_d = state_q;
        enter_o = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (insn_done_i && gie_i && hit) begin   // accept
                    state_d = ST_ENTER;
                    enter_o = 1'b1;
                end
            end
            ST_ENTER: state_d = ST_WAIT;                  // retire
        endcase
    end

    // state register and return address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (enter_o) pc_q <= pc_i;
        end
    end

    // outputs
    always_comb begin
        take_o        = 1'b0;
        gpr_we_o      = 1'b0;
        gpr_idx_o     = '0;
        gpr_data_o    = '0;
        redirect_pc_o = '0;
        unique case (state_q)
            ST_WAIT: ;
            ST_ENTER: begin
                take_o        = 1'b1;
                gpr_we_o      = 1'b1;
                gpr_idx_o     = EPC_IDX;
                gpr_data_o    = pc_q;
                redirect_pc_o = eba_i + VEC_OFS;
            end
        endcase
    end

    assert_no_take_off_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !insn_done_i) |=> !take_o);

    assert_take_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_return_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (gpr_data_o == $past(pc_i) && $past(insn_done_i)));

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit #(
    parameter int XLEN       = 32,
    parameter int NUM_IRQ    = 32,
    parameter int EXC_ID     = 6,
    parameter int EPC_REG    = 30,
    parameter int IDX_W      = 5,
    parameter int ALIGN_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               insn_done_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [1:0]         csr_sel_i,
    input  logic               csr_we_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    output logic [XLEN-1:0]    csr_rdata_o,
    output logic               take_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic               gpr_we_o,
    output logic [IDX_W-1:0]   gpr_idx_o,
    output logic [XLEN-1:0]    gpr_data_o,
    output logic [1:0]         ie_o
);

    logic [NUM_IRQ-1:0] ip, im, ip_clr;
    logic [XLEN-1:0]    eba;
    logic [1:0]         ie;
    logic               enter;

    irq_pending_reg #(.NUM_IRQ(NUM_IRQ)) u_pending (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_i (irq_i),
        .clr_i (ip_clr),
        .ip_o  (ip)
    );

    irq_csr_bank #(
        .XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .ALIGN_BITS(ALIGN_BITS)
    ) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (csr_sel_i),
        .we_i     (csr_we_i),
        .wdata_i  (csr_wdata_i),
        .enter_i  (enter),
        .ip_i     (ip),
        .rdata_o  (csr_rdata_o),
        .ie_o     (ie),
        .im_o     (im),
        .eba_o    (eba),
        .ip_clr_o (ip_clr)
    );

    irq_entry_fsm #(
        .XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .EXC_ID(EXC_ID),
        .EPC_REG(EPC_REG), .IDX_W(IDX_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .insn_done_i   (insn_done_i),
        .pc_i          (pc_i),
        .gie_i         (ie[0]),
        .im_i          (im),
        .ip_i          (ip),
        .eba_i         (eba),
        .enter_o       (enter),
        .take_o        (take_o),
        .redirect_pc_o (redirect_pc_o),
        .gpr_we_o      (gpr_we_o),
        .gpr_idx_o     (gpr_idx_o),
        .gpr_data_o    (gpr_data_o)
    );

    assign ie_o = ie;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!take_o && ie_o == 2'b00));

endmodule

// File: tb/irq_entry_unit_bench.sv
module irq_entry_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq;
    logic        done;
    logic [31:0] pc;
    logic [1:0]  sel;
    logic        we;
    logic [31:0] wd;
    logic [31:0] rdata, redir, gdata;
    logic        take, gwe;
    logic [4:0]  gidx;
    logic [1:0]  ie;

    int nchk = 0;
    int nfail = 0;

    // model state
    logic [1:0]  m_ie;
    logic [31:0] m_im, m_ip, m_eba, m_pc;
    logic        m_enter;

    always #5 clk = ~clk;

    irq_entry_unit u_irq_entry_unit (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .insn_done_i(done), .pc_i(pc),
        .csr_sel_i(sel), .csr_we_i(we), .csr_wdata_i(wd), .csr_rdata_o(rdata),
        .take_o(take), .redirect_pc_o(redir), .gpr_we_o(gwe), .gpr_idx_o(gidx),
        .gpr_data_o(gdata), .ie_o(ie)
    );

    function automatic logic [31:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0:    return {30'b0, m_ie};
            2'd1:    return m_im;
            2'd2:    return m_ip;
            default: return m_eba;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic go;
        go = !m_enter && done && m_ie[0] && ((m_im & m_ip) != 0);
        m_ip = (m_ip & ~((we && sel == 2'd2) ? wd : 32'h0)) | irq;
        if (go)                        m_ie = 2'b10;
        else if (we && sel == 2'd0)    m_ie = wd[1:0];
        if (we && sel == 2'd1)         m_im = wd;
        if (we && sel == 2'd3)         m_eba = {wd[31:8], 8'h00};
        if (go)                        m_pc = pc;
        m_enter = go;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R4"}, "take", {31'b0, take}, {31'b0, m_enter});
        chk({tag, " R5"}, "gpr_we", {31'b0, gwe}, {31'b0, m_enter});
        if (m_enter) begin
            chk({tag, " R5"}, "gpr_idx", {27'b0, gidx}, 32'd30);
            chk({tag, " R5"}, "gpr_data", gdata, m_pc);
            chk({tag, " R6"}, "redirect", redir, m_eba + 32'h0000_00C0);
        end
        chk({tag, " R7"}, "ie", {30'b0, ie}, {30'b0, m_ie});
        chk({tag, " R10"}, "rdata", rdata, exp_read(sel));
    endtask

    task automatic cyc(input logic [31:0] i_irq, input logic i_done, input logic [31:0] i_pc,
                       input logic i_we, input logic [1:0] i_sel, input logic [31:0] i_wd,
                       input string tag);
        irq = i_irq; done = i_done; pc = i_pc; we = i_we; sel = i_sel; wd = i_wd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        we = 1'b0; irq = '0; done = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; irq = '0; done = 1'b0; pc = '0; sel = '0; we = 1'b0; wd = '0;
        m_ie = '0; m_im = '0; m_ip = '0; m_eba = '0; m_pc = '0; m_enter = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int s = 0; s < 4; s++) cyc('0, 1'b0, '0, 1'b0, 2'(s), '0, "R1");

        // R8: low base bits are never stored
        cyc('0, 1'b0, '0, 1'b1, 2'd3, 32'hFFFF_FFFF, "R8");
        cyc('0, 1'b0, '0, 1'b0, 2'd3, '0, "R8");
        chk("R8", "base low byte", {24'b0, rdata[7:0]}, 32'h0);

        // R2: a pulse latches, a dropped line keeps it
        cyc(32'h0000_0020, 1'b0, '0, 1'b0, 2'd2, '0, "R2");
        cyc('0, 1'b0, '0, 1'b0, 2'd2, '0, "R2");
        chk("R2", "sticky bit5", {31'b0, rdata[5]}, 32'd1);

        // R3: clear against a still-high line keeps the bit; then clears
        cyc(32'h0000_0020, 1'b0, '0, 1'b1, 2'd2, 32'h0000_0020, "R3");
        chk("R3", "set wins", {31'b0, rdata[5]}, 32'd1);
        cyc('0, 1'b0, '0, 1'b1, 2'd2, 32'h0000_0020, "R3");
        chk("R3", "cleared", {31'b0, rdata[5]}, 32'd0);

        // R4: pending but masked -> no entry
        cyc(32'h0000_0080, 1'b0, '0, 1'b0, 2'd2, '0, "R4");
        cyc('0, 1'b0, '0, 1'b1, 2'd0, 32'h1, "R4");
        cyc('0, 1'b1, 32'h0000_1000, 1'b0, 2'd1, '0, "R4");
        chk("R4", "masked no take", {31'b0, take}, 32'd0);

        // R9: unmask, next boundary enters
        cyc('0, 1'b0, '0, 1'b1, 2'd1, 32'h0000_0080, "R9");
        cyc('0, 1'b1, 32'h0000_2000, 1'b0, 2'd0, '0, "R9");
        chk("R9", "take after unmask", {31'b0, take}, 32'd1);
        chk("R6", "vector", redir, 32'hFFFF_FFC0);
        chk("R7", "ie on entry", {30'b0, ie}, 32'd2);

        // R7: boundary during entry ignored, then enable write loses to entry
        cyc('0, 1'b1, 32'h0000_3000, 1'b1, 2'd0, 32'h1, "R7");
        chk("R4", "no take in entry cycle", {31'b0, take}, 32'd0);
        cyc('0, 1'b1, 32'h0000_4000, 1'b1, 2'd0, 32'h1, "R7");
        chk("R7", "entry beats write", {30'b0, ie}, 32'd2);
        chk("R5", "return pc", gdata, 32'h0000_4000);
        cyc('0, 1'b0, '0, 1'b1, 2'd2, 32'hFFFF_FFFF, "R3");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r_irq;
            r_irq = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
            cyc(r_irq, 1'($urandom % 2), $urandom, 1'($urandom % 4 == 0),
                2'($urandom % 4), $urandom, "rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule